// File: doc/BRIEF.md
# Nesting Vectored Interrupt Controller

This block gathers 32 level-sensitive interrupt sources and presents them to a processor as two request lines: a fast request and a normal request. Every source is the OR of a hardware input pin and a bit that software can set, and a route register sends each source to one of the two lines. Sources on the normal line can be tied to sixteen vector slots. Each slot holds a handler address and names one source, and a lower slot number means a higher priority. A default handler address serves any enabled source that is tied to no slot.

The controller keeps the current priority level in hardware, so handlers can nest. When a handler starts, it reads the current-vector register. This read returns the address of the handler that won arbitration and raises the active level to match. From then on, only sources in strictly higher-priority slots can raise the normal request. When the handler ends, it writes the same register. The write brings back the level that was active before, using a per-level record of saved levels. Register access is a simple single-cycle read/write bus with a combinational read data path.

Top module: `nest_vic`

## Requirements
- R1: Raw status (offset 0x008) is the hardware input OR the software bits. Normal status (0x000) is raw AND enable AND NOT route. Fast status (0x004) is raw AND route, where a route bit of 1 selects the fast line.
- R2: `fiq_o` is high exactly when fast status is non-zero. `irq_o` is high exactly when normal status ANDed with the mask of the current level is non-zero. At the idle level (17) that mask is all ones.
- R3: A slot control byte (0x200 + 4*n) enables the slot with bit 5 and names its source in bits 4:0. The mask of level i is the OR of the sources of enabled slots whose index is below i. Level 16 covers every enabled slot, and slot 0 has the highest priority.
- R4: A strobed read of 0x030 looks for the highest-priority level, above the current one, whose mask overlaps the raw status. If it finds one, it saves the current level for that level and makes it current. The read returns the address held for the resulting level: slot addresses at 0x100 + 4*n, and the default at 0x034 for level 16.
- R5: A strobed read of 0x030 at the idle level with no raw source set returns the default address (0x034) and leaves the level idle.
- R6: A write to 0x030 ignores its data. When the level is not idle, the write restores the level saved for the current level. At idle, the write has no effect.
- R7: Writing ones to 0x010 sets enable bits and writing ones to 0x014 clears them. Writing ones to 0x018 sets software bits and writing ones to 0x01C clears them. 0x010 reads back the enables and 0x018 reads back the software bits.
- R8: The route register (0x00C) is written and read directly. The guard register (0x020) keeps only data bit 0.
- R9: Offsets 0xFE0 to 0xFFC read the identification bytes 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in that order.
- R10: Reset clears all slot addresses, slot controls, the default address, enables, software bits, route and guard, and sets the level to idle (17).
- R11: Reads of unmapped offsets return zero. Writes to unmapped offsets, and writes to the status offset 0x000, change nothing.
- R12: The level changes only on a cycle where `rd_en_i` or `wr_en_i` is high with address 0x030. Holding that address without a strobe leaves the level as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 32 | Hardware interrupt levels |
| rd_en_i | input | 1 | Read strobe; qualifies read side effects |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 12 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from address and state |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest state to reach is two-deep nesting, followed by unwinding through the saved-level record. A lower-priority source must first be taken, then a higher-priority slot source raised while the first handler is active. The bench sets one software bit and claims it with a vector read. It checks that the request drops, sets a second software bit tied to slot 0, and claims that as well. It then pops twice and checks the returned addresses and the request line after each pop. A hardware source tied to no slot drives the level to 16 (the default level). Holding address 0x030 without a strobe shows that bus sampling alone leaves the level unchanged.

// File: rtl/nest_vic_pkg.sv
package nest_vic_pkg;

  localparam int unsigned ADDR_W = 12;
  localparam int unsigned CTL_W  = 8;
  localparam int unsigned CTL_EN_BIT = 5;

  localparam logic [ADDR_W-1:0] OFS_IRQ_STAT = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_FIQ_STAT = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_RAW      = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_ROUTE    = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_EN_SET   = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR   = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_SW_SET   = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_SW_CLR   = 12'h01C;
  localparam logic [ADDR_W-1:0] OFS_GUARD    = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_VEC_CUR  = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_VEC_DEF  = 12'h034;

  localparam logic [5:0] PAGE_VADDR = 6'h04;
  localparam logic [5:0] PAGE_VCTL  = 6'h08;
  localparam logic [6:0] PAGE_IDENT = 7'h7F;

  typedef enum logic [1:0] {
    RD_REG,
    RD_VADDR,
    RD_VCTL,
    RD_IDENT
  } rd_space_e;

  function automatic logic [7:0] ident_byte(input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0: b = 8'h90;
      3'd1: b = 8'h11;
      3'd2: b = 8'h04;
      3'd3: b = 8'h00;
      3'd4: b = 8'h0D;
      3'd5: b = 8'hF0;
      3'd6: b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/nest_vic_rst_sync.sv
module nest_vic_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/nest_vic_src_regs.sv
module nest_vic_src_regs #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic               we_route_i,
  input  logic               we_en_set_i,
  input  logic               we_en_clr_i,
  input  logic               we_sw_set_i,
  input  logic               we_sw_clr_i,
  input  logic               we_guard_i,
  output logic [NUM_SRC-1:0] route_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] sw_o,
  output logic               guard_o
);

  logic [NUM_SRC-1:0] route_q, route_d;
  logic [NUM_SRC-1:0] en_q, en_d;
  logic [NUM_SRC-1:0] sw_q, sw_d;
  logic               guard_q, guard_d;
  logic               upd;

  assign upd = we_route_i | we_en_set_i | we_en_clr_i |
               we_sw_set_i | we_sw_clr_i | we_guard_i;

  always_comb begin
    route_d = route_q;
    en_d    = en_q;
    sw_d    = sw_q;
    guard_d = guard_q;
    if (we_route_i)  route_d = wdata_i;
    if (we_en_set_i) en_d    = en_q | wdata_i;
    if (we_en_clr_i) en_d    = en_q & ~wdata_i;
    if (we_sw_set_i) sw_d    = sw_q | wdata_i;
    if (we_sw_clr_i) sw_d    = sw_q & ~wdata_i;
    if (we_guard_i)  guard_d = wdata_i[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
      en_q    <= '0;
      sw_q    <= '0;
      guard_q <= 1'b0;
    end else if (upd) begin
      route_q <= route_d;
      en_q    <= en_d;
      sw_q    <= sw_d;
      guard_q <= guard_d;
    end
  end

  assign route_o = route_q;
  assign en_o    = en_q;
  assign sw_o    = sw_q;
  assign guard_o = guard_q;

endmodule

// File: rtl/nest_vic_slot_regs.sv
module nest_vic_slot_regs
  import nest_vic_pkg::*;
#(
  parameter int unsigned NUM_SLOT = 16,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned SLOT_IW = $clog2(NUM_SLOT)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [DATA_W-1:0]                  wdata_i,
  input  logic [SLOT_IW-1:0]                 slot_i,
  input  logic                               we_vaddr_i,
  input  logic                               we_vctl_i,
  input  logic                               we_def_i,
  output logic [NUM_SLOT:0][DATA_W-1:0]      vaddr_o,
  output logic [NUM_SLOT-1:0][CTL_W-1:0]     vctl_o
);

  logic [NUM_SLOT:0][DATA_W-1:0]  vaddr_q, vaddr_d;
  logic [NUM_SLOT-1:0][CTL_W-1:0] vctl_q, vctl_d;
  logic                           upd;

  assign upd = we_vaddr_i | we_vctl_i | we_def_i;

  always_comb begin
    vaddr_d = vaddr_q;
    vctl_d  = vctl_q;
    if (we_vaddr_i) vaddr_d[slot_i]   = wdata_i;
    if (we_vctl_i)  vctl_d[slot_i]    = wdata_i[CTL_W-1:0];
    if (we_def_i)   vaddr_d[NUM_SLOT] = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q <= '0;
      vctl_q  <= '0;
    end else if (upd) begin
      vaddr_q <= vaddr_d;
      vctl_q  <= vctl_d;
    end
  end

  assign vaddr_o = vaddr_q;
  assign vctl_o  = vctl_q;

endmodule

// File: rtl/nest_vic_mask_gen.sv
module nest_vic_mask_gen
  import nest_vic_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned NUM_SLOT = 16,
  localparam int unsigned SRC_IW  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SLOT-1:0][CTL_W-1:0]  vctl_i,
  output logic [NUM_SLOT+1:0][NUM_SRC-1:0] mask_o
);

  logic [NUM_SLOT-1:0][NUM_SRC-1:0] slot_bit;

  // Level 0 masks everything; each further level adds the source of the
  // slot just above it; the idle level lets every source through.
  assign mask_o[0] = '0;

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
    assign slot_bit[g]   = vctl_i[g][CTL_EN_BIT]
                           ? (NUM_SRC'(1) << vctl_i[g][SRC_IW-1:0])
                           : '0;
    assign mask_o[g+1]   = mask_o[g] | slot_bit[g];
  end

  assign mask_o[NUM_SLOT+1] = '1;

endmodule

// File: rtl/nest_vic_nest_ctl.sv
module nest_vic_nest_ctl #(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned NUM_SLOT = 16,
  localparam int unsigned LVL_W   = $clog2(NUM_SLOT + 2),
  localparam logic [LVL_W-1:0] LVL_IDLE = LVL_W'(NUM_SLOT + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_SRC-1:0]               raw_i,
  input  logic [NUM_SLOT+1:0][NUM_SRC-1:0] mask_i,
  input  logic                             vec_rd_i,
  input  logic                             vec_wr_i,
  output logic [LVL_W-1:0]                 cur_lvl_o,
  output logic [LVL_W-1:0]                 vec_lvl_o
);

  logic [LVL_W-1:0]              cur_q, cur_d;
  logic [NUM_SLOT:0][LVL_W-1:0]  prev_q, prev_d;
  logic [LVL_W-1:0]              tgt;
  logic                          hit;
  logic                          upd;

  // Highest-priority level above the current one whose mask meets a
  // raw source; scanning downward lets the lowest index win.
  always_comb begin
    tgt = cur_q;
    for (int i = NUM_SLOT; i >= 0; i--) begin
      if ((i < int'(cur_q)) && (|(raw_i & mask_i[i+1]))) begin
        tgt = LVL_W'(i);
      end
    end
  end

  assign hit = (tgt != cur_q);
  assign upd = vec_rd_i | vec_wr_i;

  always_comb begin
    cur_d  = cur_q;
    prev_d = prev_q;
    if (vec_rd_i) begin
      if (hit) begin
        prev_d[tgt] = cur_q;
        cur_d       = tgt;
      end
    end else if (vec_wr_i && (cur_q != LVL_IDLE)) begin
      cur_d = prev_q[cur_q];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= LVL_IDLE;
      prev_q <= {(NUM_SLOT+1){LVL_IDLE}};
    end else if (upd) begin
      cur_q  <= cur_d;
      prev_q <= prev_d;
    end
  end

  assign cur_lvl_o = cur_q;
  assign vec_lvl_o = (tgt == LVL_IDLE) ? LVL_W'(NUM_SLOT) : tgt;

endmodule

// File: rtl/nest_vic.sv
module nest_vic
  import nest_vic_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned NUM_SLOT = 16,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic                rd_en_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                irq_o,
  output logic                fiq_o
);

  localparam int unsigned SLOT_IW = $clog2(NUM_SLOT);
  localparam int unsigned LVL_W   = $clog2(NUM_SLOT + 2);

  logic                             rst_sync_n;
  logic [ADDR_W-1:0]                addr_w;
  logic [SLOT_IW-1:0]               slot_idx;
  logic                             slot_ok;
  logic                             in_vaddr, in_vctl, in_ident;
  rd_space_e                        rd_space;
  logic                             vec_rd, vec_wr;
  logic [NUM_SRC-1:0]               route_q, en_q, sw_q;
  logic                             guard_q;
  logic [NUM_SRC-1:0]               raw_stat, irq_stat, fiq_stat;
  logic [NUM_SLOT:0][DATA_W-1:0]    vaddr_q;
  logic [NUM_SLOT-1:0][CTL_W-1:0]   vctl_q;
  logic [NUM_SLOT+1:0][NUM_SRC-1:0] lvl_mask;
  logic [LVL_W-1:0]                 cur_lvl, vec_lvl;
  logic [DATA_W-1:0]                reg_rdata;
  logic [1:0]                       unused_addr_lsb;

  nest_vic_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Address decode
  assign addr_w          = {addr_i[ADDR_W-1:2], 2'b00};
  assign unused_addr_lsb = addr_i[1:0];
  assign slot_idx        = addr_i[SLOT_IW+1:2];
  assign slot_ok         = ({1'b0, addr_i[5:2]} < 5'(NUM_SLOT));
  assign in_vaddr        = (addr_i[11:6] == PAGE_VADDR) && slot_ok;
  assign in_vctl         = (addr_i[11:6] == PAGE_VCTL) && slot_ok;
  assign in_ident        = (addr_i[11:5] == PAGE_IDENT);

  always_comb begin
    if (in_vaddr)      rd_space = RD_VADDR;
    else if (in_vctl)  rd_space = RD_VCTL;
    else if (in_ident) rd_space = RD_IDENT;
    else               rd_space = RD_REG;
  end

  assign vec_rd = rd_en_i && (addr_w == OFS_VEC_CUR);
  assign vec_wr = wr_en_i && (addr_w == OFS_VEC_CUR);

  nest_vic_src_regs #(.NUM_SRC(NUM_SRC)) src_regs_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wdata_i     (wdata_i[NUM_SRC-1:0]),
    .we_route_i  (wr_en_i && (addr_w == OFS_ROUTE)),
    .we_en_set_i (wr_en_i && (addr_w == OFS_EN_SET)),
    .we_en_clr_i (wr_en_i && (addr_w == OFS_EN_CLR)),
    .we_sw_set_i (wr_en_i && (addr_w == OFS_SW_SET)),
    .we_sw_clr_i (wr_en_i && (addr_w == OFS_SW_CLR)),
    .we_guard_i  (wr_en_i && (addr_w == OFS_GUARD)),
    .route_o     (route_q),
    .en_o        (en_q),
    .sw_o        (sw_q),
    .guard_o     (guard_q)
  );

  nest_vic_slot_regs #(.NUM_SLOT(NUM_SLOT), .DATA_W(DATA_W)) slot_regs_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wdata_i    (wdata_i),
    .slot_i     (slot_idx),
    .we_vaddr_i (wr_en_i && in_vaddr),
    .we_vctl_i  (wr_en_i && in_vctl),
    .we_def_i   (wr_en_i && (addr_w == OFS_VEC_DEF)),
    .vaddr_o    (vaddr_q),
    .vctl_o     (vctl_q)
  );

  nest_vic_mask_gen #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT)) mask_gen_i (
    .vctl_i (vctl_q),
    .mask_o (lvl_mask)
  );

  assign raw_stat = src_i | sw_q;
  assign irq_stat = raw_stat & en_q & ~route_q;
  assign fiq_stat = raw_stat & route_q;

  nest_vic_nest_ctl #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT)) nest_ctl_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .raw_i     (raw_stat),
    .mask_i    (lvl_mask),
    .vec_rd_i  (vec_rd),
    .vec_wr_i  (vec_wr),
    .cur_lvl_o (cur_lvl),
    .vec_lvl_o (vec_lvl)
  );

  assign irq_o = |(irq_stat & lvl_mask[cur_lvl]);
  assign fiq_o = |fiq_stat;

  // Read data
  always_comb begin
    reg_rdata = '0;
    case (addr_w)
      OFS_IRQ_STAT: reg_rdata = DATA_W'(irq_stat);
      OFS_FIQ_STAT: reg_rdata = DATA_W'(fiq_stat);
      OFS_RAW:      reg_rdata = DATA_W'(raw_stat);
      OFS_ROUTE:    reg_rdata = DATA_W'(route_q);
      OFS_EN_SET:   reg_rdata = DATA_W'(en_q);
      OFS_SW_SET:   reg_rdata = DATA_W'(sw_q);
      OFS_GUARD:    reg_rdata = DATA_W'(guard_q);
      OFS_VEC_CUR:  reg_rdata = vaddr_q[vec_lvl];
      OFS_VEC_DEF:  reg_rdata = vaddr_q[NUM_SLOT];
      default:      reg_rdata = '0;
    endcase
  end

  always_comb begin
    case (rd_space)
      RD_VADDR: rdata_o = vaddr_q[slot_idx];
      RD_VCTL:  rdata_o = DATA_W'(vctl_q[slot_idx]);
      RD_IDENT: rdata_o = DATA_W'(ident_byte(addr_i[4:2]));
      default:  rdata_o = reg_rdata;
    endcase
  end

endmodule

// File: rtl/nest_vic_chk.sv
module nest_vic_chk #(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned NUM_SLOT = 16,
  localparam int unsigned LVL_W   = $clog2(NUM_SLOT + 2),
  localparam logic [LVL_W-1:0] LVL_IDLE = LVL_W'(NUM_SLOT + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_o,
  input logic               fiq_o,
  input logic               rd_en_i,
  input logic               vec_rd,
  input logic               vec_wr,
  input logic [NUM_SRC-1:0] raw_stat,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] route_q,
  input logic [LVL_W-1:0]   cur_lvl
);

  // R1: the fast line needs a routed raw source
  p_fiq_routed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> (|(raw_stat & route_q)));

  // R2: the normal line needs an enabled, unrouted raw source
  p_irq_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(raw_stat & en_q & ~route_q)));

  // R2: at idle nothing is masked
  p_idle_unmasked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl == LVL_IDLE) |-> (irq_o == (|(raw_stat & en_q & ~route_q))));

  // R4: a vector read never lowers the priority (level number never grows)
  p_read_raises_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd |=> (cur_lvl <= $past(cur_lvl)));

  // R6: a pop from a non-idle level returns to a lower priority
  p_pop_lowers_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_wr && !rd_en_i && (cur_lvl != LVL_IDLE)) |=> (cur_lvl > $past(cur_lvl)));

  // R12: the level only moves after a strobed vector access
  p_strobe_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl != $past(cur_lvl)) |-> $past(vec_rd || vec_wr));

  // R10: level never leaves the legal range
  p_level_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cur_lvl <= LVL_IDLE);

endmodule

bind nest_vic nest_vic_chk #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT)) chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .rd_en_i  (rd_en_i),
  .vec_rd   (vec_rd),
  .vec_wr   (vec_wr),
  .raw_stat (raw_stat),
  .en_q     (en_q),
  .route_q  (route_q),
  .cur_lvl  (cur_lvl)
);

// File: tb/nest_vic_tb_top.sv
`timescale 1ns/100ps
module nest_vic_tb_top;

  localparam logic [1:0] OP_WR  = 2'd0;
  localparam logic [1:0] OP_RD  = 2'd1;
  localparam logic [1:0] OP_PIN = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] expv;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 56;

  // op, addr, data, expected, requirement; pin checks expect {fiq,irq}
  localparam vec_t VECS [NVEC] = '{
    '{OP_WR,  12'h200, 32'h0000_0023, 32'h0,          4'd3},  // R3 slot0 -> src3
    '{OP_WR,  12'h204, 32'h0000_0025, 32'h0,          4'd3},  // R3 slot1 -> src5
    '{OP_WR,  12'h100, 32'hA000_0000, 32'h0,          4'd4},
    '{OP_WR,  12'h104, 32'hA000_0004, 32'h0,          4'd4},
    '{OP_WR,  12'h034, 32'hDEF0_0000, 32'h0,          4'd5},
    '{OP_RD,  12'h200, 32'h0,         32'h0000_0023,  4'd3},
    '{OP_RD,  12'h204, 32'h0,         32'h0000_0025,  4'd3},
    '{OP_RD,  12'h034, 32'h0,         32'hDEF0_0000,  4'd5},
    '{OP_WR,  12'h010, 32'h0000_0028, 32'h0,          4'd7},  // R7 enable set
    '{OP_WR,  12'h014, 32'h0000_0008, 32'h0,          4'd7},
    '{OP_RD,  12'h010, 32'h0,         32'h0000_0020,  4'd7},
    '{OP_WR,  12'h010, 32'h0000_0008, 32'h0,          4'd7},
    '{OP_RD,  12'h010, 32'h0,         32'h0000_0028,  4'd7},
    '{OP_WR,  12'h018, 32'h0000_0020, 32'h0,          4'd7},
    '{OP_RD,  12'h018, 32'h0,         32'h0000_0020,  4'd7},
    '{OP_RD,  12'h008, 32'h0,         32'h0000_0020,  4'd1},  // R1 raw
    '{OP_RD,  12'h000, 32'h0,         32'h0000_0020,  4'd1},
    '{OP_PIN, 12'h000, 32'h0,         32'h1,          4'd2},  // R2
    '{OP_RD,  12'h030, 32'h0,         32'hA000_0004,  4'd4},  // R4 claim slot1
    '{OP_PIN, 12'h000, 32'h0,         32'h0,          4'd2},
    '{OP_WR,  12'h018, 32'h0000_0008, 32'h0,          4'd7},
    '{OP_PIN, 12'h000, 32'h0,         32'h1,          4'd2},  // higher prio pierces
    '{OP_RD,  12'h030, 32'h0,         32'hA000_0000,  4'd4},  // nest to slot0
    '{OP_PIN, 12'h000, 32'h0,         32'h0,          4'd2},
    '{OP_RD,  12'h030, 32'h0,         32'hA000_0000,  4'd4},
    '{OP_WR,  12'h01C, 32'h0000_0008, 32'h0,          4'd7},
    '{OP_WR,  12'h030, 32'h0000_FFFF, 32'h0,          4'd6},  // R6 pop to 1
    '{OP_RD,  12'h030, 32'h0,         32'hA000_0004,  4'd6},
    '{OP_WR,  12'h030, 32'h0,         32'h0,          4'd6},  // pop to idle
    '{OP_PIN, 12'h000, 32'h0,         32'h1,          4'd6},
    '{OP_WR,  12'h01C, 32'h0000_0020, 32'h0,          4'd7},
    '{OP_PIN, 12'h000, 32'h0,         32'h0,          4'd2},
    '{OP_RD,  12'h030, 32'h0,         32'hDEF0_0000,  4'd5},  // R5 empty idle read
    '{OP_PIN, 12'h000, 32'h0,         32'h0,          4'd5},
    '{OP_WR,  12'h010, 32'h0000_0080, 32'h0,          4'd7},
    '{OP_WR,  12'h00C, 32'h0000_0080, 32'h0,          4'd8},  // R8 route src7
    '{OP_WR,  12'h018, 32'h0000_0080, 32'h0,          4'd7},
    '{OP_RD,  12'h004, 32'h0,         32'h0000_0080,  4'd1},
    '{OP_RD,  12'h000, 32'h0,         32'h0,          4'd1},
    '{OP_RD,  12'h008, 32'h0,         32'h0000_0080,  4'd1},
    '{OP_PIN, 12'h000, 32'h0,         32'h2,          4'd2},
    '{OP_RD,  12'h00C, 32'h0,         32'h0000_0080,  4'd8},
    '{OP_WR,  12'h000, 32'hFFFF_FFFF, 32'h0,          4'd11}, // R11
    '{OP_RD,  12'h000, 32'h0,         32'h0,          4'd11},
    '{OP_WR,  12'h020, 32'h0000_00FF, 32'h0,          4'd8},
    '{OP_RD,  12'h020, 32'h0,         32'h0000_0001,  4'd8},
    '{OP_WR,  12'h024, 32'h0000_FFFF, 32'h0,          4'd11},
    '{OP_RD,  12'h024, 32'h0,         32'h0,          4'd11},
    '{OP_RD,  12'h040, 32'h0,         32'h0,          4'd11},
    '{OP_RD,  12'hFE0, 32'h0,         32'h0000_0090,  4'd9},  // R9
    '{OP_RD,  12'hFE4, 32'h0,         32'h0000_0011,  4'd9},
    '{OP_RD,  12'hFF0, 32'h0,         32'h0000_000D,  4'd9},
    '{OP_RD,  12'hFFC, 32'h0,         32'h0000_00B1,  4'd9},
    '{OP_WR,  12'h01C, 32'h0000_0080, 32'h0,          4'd7},
    '{OP_WR,  12'h00C, 32'h0,         32'h0,          4'd8},
    '{OP_PIN, 12'h000, 32'h0,         32'h0,          4'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src;
  logic        rd_en, wr_en;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq, fiq;
  int          n_checks = 0;
  int          n_errs   = 0;

  always #2.5 clk = ~clk;

  nest_vic dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_i   (src),
    .rd_en_i (rd_en),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq),
    .fiq_o   (fiq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] expv, input string tag);
    n_checks++;
    if (act !== expv) begin
      n_errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, input logic [31:0] expv, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 check(rdata, expv, tag);
    @(posedge clk);
    #1 rd_en = 1'b0;
  endtask

  task automatic do_pins(input logic exp_fiq, input logic exp_irq, input string tag);
    @(negedge clk);
    #1 check({30'b0, fiq, irq}, {30'b0, exp_fiq, exp_irq}, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; src = '0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset state
    do_pins(1'b0, 1'b0, "R10 pins");
    do_read(12'h100, 32'h0, "R10 slot addr");
    do_read(12'h200, 32'h0, "R10 slot ctl");
    do_read(12'h034, 32'h0, "R10 default");
    do_read(12'h010, 32'h0, "R10 enable");
    do_read(12'h020, 32'h0, "R10 guard");
    do_read(12'h030, 32'h0, "R10 idle vector");

    // Table walk (R1..R11)
    for (int k = 0; k < NVEC; k++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[k].req, k);
      case (VECS[k].op)
        OP_WR:   do_write(VECS[k].addr, VECS[k].data);
        OP_RD:   do_read(VECS[k].addr, VECS[k].expv, tag);
        default: do_pins(VECS[k].expv[1], VECS[k].expv[0], tag);
      endcase
    end

    // R1: hardware input on an enabled source tied to no slot
    do_write(12'h010, 32'h0000_0200);
    @(negedge clk); src = 32'h0000_0200;
    do_pins(1'b0, 1'b1, "R1 hw source");

    // R12: address parked on the vector register without a strobe
    @(negedge clk); addr = 12'h030;
    repeat (3) @(negedge clk);
    do_pins(1'b0, 1'b1, "R12 no strobe keeps level");

    // R4: unslotted source claims the default level 16
    do_read(12'h030, 32'hDEF0_0000, "R4 default level");
    do_pins(1'b0, 1'b0, "R4 level16 masks unslotted");
    do_write(12'h030, 32'h0);
    do_pins(1'b0, 1'b1, "R6 pop to idle");

    // R3: two slotted sources pending, slot 0 wins
    @(negedge clk); src = 32'h0000_0228;
    do_read(12'h030, 32'hA000_0000, "R3 slot0 priority");
    do_pins(1'b0, 1'b0, "R3 level0 masks all");
    do_write(12'h030, 32'h0);
    do_pins(1'b0, 1'b1, "R6 back to idle");
    @(negedge clk); src = '0;
    do_pins(1'b0, 1'b0, "R1 hw released");

    // R10: reset in mid-run clears programming
    do_reset();
    do_read(12'h200, 32'h0, "R10 ctl after reset");
    do_read(12'h104, 32'h0, "R10 addr after reset");
    do_read(12'h034, 32'h0, "R10 default after reset");
    do_read(12'h010, 32'h0, "R10 enable after reset");

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule